// File: doc/BRIEF.md
# Search-Engine Read Address Controller

This block sits between the command front end of a search-engine device and its storage. It receives read commands and turns each one into one or more internal read accesses. Each access carries a target code, a 15-bit location address and a valid strobe. A command names one of four targets: the data array, the mask array, the external SRAM or the device-register space. For the first three it also picks how the address is formed. In direct mode the address is taken straight from the command word. In indirect mode the address comes from one of eight stored search-result registers, and the two low address bits are ORed with bits of the command word.

A burst read walks a run of consecutive locations in the data or mask array, one access per clock. The start address and the run length come from a burst configuration register rather than from the command word. While more burst accesses are still to come, a busy flag is high and new commands are refused. A burst request aimed at the SRAM or the register space is carried out as a single read, and a one-cycle error flag is raised with it. The eight search-result registers and the burst register are loaded through a small write-only side port.

Top module: `rd_addr_ctrl`

## Requirements
- R1: A single read accepted on a clock edge (cmd_vld high, busy low) drives acc_vld high for exactly the next cycle. acc_tgt equals word bits [20:19] (0 data, 1 mask, 2 SRAM, 3 registers). In direct mode (word bit 29 = 0), acc_addr equals word bits [14:0].
- R2: In indirect mode (word bit 29 = 1), bits [28:26] select one of eight search-result registers S. The address is {S[14:2], S[1] | word[1], S[0] | word[0]}, and the other address bits of the word play no part.
- R3: Word bits [67:30], [25:21] and [18:15] have no effect on any output.
- R4: A burst read (cmd_burst = 1) to the data or mask array with a burst length L > 0 issues L accesses on L consecutive cycles, starting in the cycle after acceptance. The addresses run from the burst start address upward by one, wrapping modulo 2^15. acc_tgt is taken from word bits [20:19].
- R5: A burst read to the data or mask array with a burst length of 0 issues no access and leaves busy low.
- R6: A burst read to the SRAM or the register space is performed as a single read with the address from R1/R2. burst_err is high for that one access cycle only. burst_err is never high at any other time.
- R7: busy is high exactly in those burst access cycles that are followed by another burst access. Commands presented while busy is high are ignored, and the burst continues unchanged.
- R8: Target code 3 reads the device-register space with the same address rules as the other targets.
- R9: On a clock edge with cfg_we high, cfg_addr 0..7 loads search-result register cfg_addr with cfg_wdata[14:0]. cfg_addr 8 loads the burst start address from cfg_wdata[14:0] and the burst length from cfg_wdata[23:15].
- R10: After reset, acc_vld, busy and burst_err are low, and all search-result registers and the burst register hold zero.
- R11: When the block is idle and no command is presented, acc_vld stays low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | Read command strobe |
| cmd_burst | input | 1 | 0 single read, 1 burst read |
| cmd_word | input | 68 | Command word with target, mode, index and address fields |
| cfg_we | input | 1 | Side-port write enable |
| cfg_addr | input | 4 | Side-port register select (0..7 result registers, 8 burst register) |
| cfg_wdata | input | 24 | Side-port write data |
| acc_vld | output | 1 | Access strobe, one per issued address |
| acc_tgt | output | 2 | Access target code |
| acc_addr | output | 15 | Access location address |
| busy | output | 1 | More burst accesses pending; commands refused |
| burst_err | output | 1 | Burst request demoted to a single read |

## Verification
Every output is registered in the sequencer, so a corrupted state shows up at the ports one cycle after the edge that produced it. A stale or misloaded result register shows as a wrong address on the single access that follows an indirect command. An error in the burst counter shows as one access too many or too few, or as busy falling in the wrong cycle; the step-by-one check catches an address skip on the very next cycle. Refusal while busy is tested by presenting a conflicting command in the middle of a burst and watching the address run stay on course.

// File: rtl/rdac_pkg.sv
// Package: shared field positions, widths and target codes for the read
// address controller. Assumes the 68-bit command word layout below.
package rdac_pkg;

    localparam int CMD_W      = 68;
    localparam int ADDR_W     = 15;
    localparam int LEN_W      = 9;
    localparam int NUM_SSR    = 8;
    localparam int SSR_IDX_W  = $clog2(NUM_SSR);
    localparam int CFG_A_W    = 4;
    localparam int CFG_D_W    = ADDR_W + LEN_W;

    // Field positions inside the command word
    localparam int POS_MODE   = 29;
    localparam int POS_IDX_LO = 26;
    localparam int POS_TGT_LO = 19;
    localparam int POS_ADDR   = 0;
    localparam int OR_BITS    = 2;   // low address bits ORed in indirect mode

    // Side-port address of the burst configuration register
    localparam logic [CFG_A_W-1:0] CFG_BURST = CFG_A_W'(NUM_SSR);

    typedef enum logic [1:0] {
        TGT_DATA = 2'b00,
        TGT_MASK = 2'b01,
        TGT_SRAM = 2'b10,
        TGT_REGS = 2'b11
    } tgt_e;

endpackage

// File: rtl/rdac_regs.sv
// Module: rdac_regs
// Holds the stored search-result registers and the burst configuration
// register, loaded through a write-only side port.
// Assumes cfg_addr values above NUM_SSR are unused and ignored.
module rdac_regs
    import rdac_pkg::*;
#(
    parameter int N_SSR = NUM_SSR,
    parameter int AW    = ADDR_W,
    parameter int LW    = LEN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_A_W-1:0]   cfg_addr,
    input  logic [AW+LW-1:0]     cfg_wdata,
    output logic [N_SSR*AW-1:0]  ssr_flat,
    output logic [AW-1:0]        bst_start,
    output logic [LW-1:0]        bst_len
);

    localparam logic [CFG_A_W-1:0] BURST_SEL = CFG_A_W'(N_SSR);

    genvar g;
    generate
        for (g = 0; g < N_SSR; g++) begin : g_ssr
            logic [AW-1:0] ssr_q;
            // Load one result register when the side port selects it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ssr_q <= '0;
                end else if (cfg_we && cfg_addr == CFG_A_W'(g)) begin
                    ssr_q <= cfg_wdata[AW-1:0];
                end
            end
            assign ssr_flat[g*AW +: AW] = ssr_q;
        end
    endgenerate

    // Load the burst start address and length from one side-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst_start <= '0;
            bst_len   <= '0;
        end else if (cfg_we && cfg_addr == BURST_SEL) begin
            bst_start <= cfg_wdata[AW-1:0];
            bst_len   <= cfg_wdata[AW +: LW];
        end
    end

endmodule

// File: rtl/rdac_decode.sv
// Module: rdac_decode
// Combinational decode of a command word into target code and address.
// Direct mode takes the address field as is. Indirect mode takes a stored
// result register and ORs its low bits with the word's low bits.
// Assumes reserved word bits are dropped here and nowhere used.
module rdac_decode
    import rdac_pkg::*;
#(
    parameter int N_SSR = NUM_SSR,
    parameter int AW    = ADDR_W
) (
    input  logic [CMD_W-1:0]     word,
    input  logic [N_SSR*AW-1:0]  ssr_flat,
    output tgt_e                 dec_tgt,
    output logic [AW-1:0]        dec_addr
);

    localparam int IW = $clog2(N_SSR);

    logic          indirect;
    logic [IW-1:0] sel;
    logic [AW-1:0] sel_ssr;
    logic [AW-1:0] direct_addr;

    assign indirect    = word[POS_MODE];
    assign sel         = word[POS_IDX_LO +: IW];
    assign direct_addr = word[POS_ADDR +: AW];

    // Pick the selected search-result register.
    always_comb begin
        sel_ssr = '0;
        for (int i = 0; i < N_SSR; i++) begin
            if (sel == IW'(i)) sel_ssr = ssr_flat[i*AW +: AW];
        end
    end

    // Form the address in direct or indirect mode and pass the target code.
    always_comb begin
        dec_tgt = tgt_e'(word[POS_TGT_LO +: 2]);
        if (indirect) begin
            dec_addr = {sel_ssr[AW-1:OR_BITS],
                        sel_ssr[OR_BITS-1:0] | direct_addr[OR_BITS-1:0]};
        end else begin
            dec_addr = direct_addr;
        end
    end

    // Reserved fields and the unused address bits in indirect mode.
    logic unused_rsvd;
    assign unused_rsvd = ^{word[CMD_W-1:POS_MODE+1],
                           word[POS_IDX_LO-1:POS_TGT_LO+2],
                           word[POS_TGT_LO-1:AW]};

endmodule

// File: rtl/rdac_seq.sv
// Module: rdac_seq
// Access sequencer: accepts a decoded command when idle, issues a single
// access or a run of burst accesses, and raises busy while more are due.
// Assumes decoded inputs are valid in the cycle cmd_vld is high.
module rdac_seq
    import rdac_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld,
    input  logic          cmd_burst,
    input  tgt_e          dec_tgt,
    input  logic [AW-1:0] dec_addr,
    input  logic [AW-1:0] bst_start,
    input  logic [LW-1:0] bst_len,
    output logic          acc_vld,
    output tgt_e          acc_tgt,
    output logic [AW-1:0] acc_addr,
    output logic          busy,
    output logic          burst_err
);

    logic [LW-1:0] remain;
    logic          accept;
    logic          array_tgt;

    assign accept    = cmd_vld && !busy;
    assign array_tgt = (dec_tgt == TGT_DATA) || (dec_tgt == TGT_MASK);

    // Issue accesses: continue a burst, start a new command, or go quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_vld   <= 1'b0;
            acc_tgt   <= TGT_DATA;
            acc_addr  <= '0;
            busy      <= 1'b0;
            burst_err <= 1'b0;
            remain    <= '0;
        end else if (busy) begin
            acc_vld   <= 1'b1;
            acc_addr  <= acc_addr + 1'b1;
            remain    <= remain - 1'b1;
            busy      <= (remain != LW'(1));
            burst_err <= 1'b0;
        end else if (accept && cmd_burst && array_tgt) begin
            acc_tgt   <= dec_tgt;
            acc_addr  <= bst_start;
            burst_err <= 1'b0;
            if (bst_len == '0) begin
                acc_vld <= 1'b0;
                busy    <= 1'b0;
                remain  <= '0;
            end else begin
                acc_vld <= 1'b1;
                remain  <= bst_len - 1'b1;
                busy    <= (bst_len != LW'(1));
            end
        end else if (accept) begin
            acc_vld   <= 1'b1;
            acc_tgt   <= dec_tgt;
            acc_addr  <= dec_addr;
            burst_err <= cmd_burst;
            busy      <= 1'b0;
        end else begin
            acc_vld   <= 1'b0;
            burst_err <= 1'b0;
        end
    end

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> acc_vld && acc_addr == AW'($past(acc_addr) + 1'b1)); // R4
    AST_BURST_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> acc_vld && (acc_tgt == TGT_DATA || acc_tgt == TGT_MASK)); // R4
    AST_ERR_ONLY_DEMOTED: assert property (@(posedge clk) disable iff (!rst_n)
        burst_err |-> acc_vld && !busy && (acc_tgt == TGT_SRAM || acc_tgt == TGT_REGS)); // R6
    AST_BUSY_HOLDS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(acc_tgt) && !burst_err); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_vld) |=> !acc_vld && !burst_err); // R11

endmodule

// File: rtl/rd_addr_ctrl.sv
// Module: rd_addr_ctrl
// Top of the read address controller: side-port register file, command
// decoder and access sequencer.
// Assumes the caller holds cmd_word stable only in the cycle of cmd_vld.
module rd_addr_ctrl
    import rdac_pkg::*;
#(
    parameter int N_SSR = NUM_SSR,
    parameter int AW    = ADDR_W,
    parameter int LW    = LEN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_vld,
    input  logic                 cmd_burst,
    input  logic [CMD_W-1:0]     cmd_word,
    input  logic                 cfg_we,
    input  logic [CFG_A_W-1:0]   cfg_addr,
    input  logic [AW+LW-1:0]     cfg_wdata,
    output logic                 acc_vld,
    output logic [1:0]           acc_tgt,
    output logic [AW-1:0]        acc_addr,
    output logic                 busy,
    output logic                 burst_err
);

    logic [N_SSR*AW-1:0] ssr_flat;
    logic [AW-1:0]       bst_start;
    logic [LW-1:0]       bst_len;
    tgt_e                dec_tgt;
    logic [AW-1:0]       dec_addr;
    tgt_e                seq_tgt;

    rdac_regs #(.N_SSR(N_SSR), .AW(AW), .LW(LW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ssr_flat  (ssr_flat),
        .bst_start (bst_start),
        .bst_len   (bst_len)
    );

    rdac_decode #(.N_SSR(N_SSR), .AW(AW)) u_dec (
        .word     (cmd_word),
        .ssr_flat (ssr_flat),
        .dec_tgt  (dec_tgt),
        .dec_addr (dec_addr)
    );

    rdac_seq #(.AW(AW), .LW(LW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld   (cmd_vld),
        .cmd_burst (cmd_burst),
        .dec_tgt   (dec_tgt),
        .dec_addr  (dec_addr),
        .bst_start (bst_start),
        .bst_len   (bst_len),
        .acc_vld   (acc_vld),
        .acc_tgt   (seq_tgt),
        .acc_addr  (acc_addr),
        .busy      (busy),
        .burst_err (burst_err)
    );

    assign acc_tgt = seq_tgt;

endmodule

// File: tb/sim_rd_addr_ctrl.sv
module sim_rd_addr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_vld = 1'b0;
    logic        cmd_burst = 1'b0;
    logic [67:0] cmd_word = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        acc_vld;
    logic [1:0]  acc_tgt;
    logic [14:0] acc_addr;
    logic        busy;
    logic        burst_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rd_addr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_burst(cmd_burst),
        .cmd_word(cmd_word), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_vld(acc_vld), .acc_tgt(acc_tgt),
        .acc_addr(acc_addr), .busy(busy), .burst_err(burst_err)
    );

    function automatic logic [67:0] mk(logic [37:0] hi, logic ind, logic [2:0] idx,
                                       logic [4:0] r1, logic [1:0] tgt, logic [3:0] r2,
                                       logic [14:0] a);
        return {hi, ind, idx, r1, tgt, r2, a};
    endfunction

    typedef struct packed {
        logic        burst;
        logic [67:0] word;
        logic [1:0]  tgt;
        logic [14:0] addr;
        logic        err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, mk(38'h0, 1'b0, 3'd0, 5'h00, 2'd0, 4'h0, 15'h0123), 2'd0, 15'h0123, 1'b0}, // R1
        '{1'b0, mk('1,    1'b0, 3'd0, 5'h1F, 2'd1, 4'hF, 15'h7FFF), 2'd1, 15'h7FFF, 1'b0}, // R3
        '{1'b0, mk(38'h0, 1'b0, 3'd5, 5'h00, 2'd2, 4'h0, 15'h2AAA), 2'd2, 15'h2AAA, 1'b0}, // R1
        '{1'b0, mk(38'h0, 1'b0, 3'd0, 5'h00, 2'd3, 4'h0, 15'h0005), 2'd3, 15'h0005, 1'b0}, // R8
        '{1'b0, mk('1,    1'b1, 3'd3, 5'h1F, 2'd0, 4'hF, 15'h7FFE), 2'd0, 15'h1232, 1'b0}, // R2
        '{1'b0, mk(38'h0, 1'b1, 3'd6, 5'h00, 2'd1, 4'h0, 15'h0002), 2'd1, 15'h4AB7, 1'b0}, // R2
        '{1'b1, mk(38'h0, 1'b0, 3'd0, 5'h00, 2'd2, 4'h0, 15'h0042), 2'd2, 15'h0042, 1'b1}, // R6
        '{1'b1, mk(38'h0, 1'b1, 3'd3, 5'h00, 2'd3, 4'h0, 15'h0001), 2'd3, 15'h1231, 1'b1}, // R6
        '{1'b0, mk(38'h0, 1'b1, 3'd0, 5'h00, 2'd3, 4'h0, 15'h0003), 2'd3, 15'h0003, 1'b0}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present a command for one edge; return at the negedge after it.
    task automatic issue(input logic b, input logic [67:0] w);
        @(negedge clk);
        cmd_vld = 1'b1; cmd_burst = b; cmd_word = w;
        @(negedge clk);
        cmd_vld = 1'b0; cmd_burst = 1'b0; cmd_word = '0;
    endtask

    task automatic check_acc(input string req, input logic [1:0] t, input logic [14:0] a,
                             input logic e, input logic bz);
        check({req, " vld"}, 32'(acc_vld), 32'd1);
        check({req, " tgt"}, 32'(acc_tgt), 32'(t));
        check({req, " addr"}, 32'(acc_addr), 32'(a));
        check({req, " err"}, 32'(burst_err), 32'(e));
        check({req, " busy"}, 32'(busy), 32'(bz));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 vld", 32'(acc_vld), 0);
        check("R10 busy", 32'(busy), 0);
        check("R10 err", 32'(burst_err), 0);

        // R9: load result registers 3 and 6
        cfg_write(4'd3, 24'h001230);
        cfg_write(4'd6, 24'h004AB5);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].burst, VECS[i].word);
            check_acc($sformatf("R1/R2/R3/R6/R8 vec%0d", i), VECS[i].tgt, VECS[i].addr,
                      VECS[i].err, 1'b0);
            @(negedge clk);
            check($sformatf("R11 vec%0d idle", i), 32'(acc_vld), 0);
            check($sformatf("R6 vec%0d err pulse", i), 32'(burst_err), 0);
        end

        // R4/R7/R9: burst on mask array, start 0x7FFE, length 4, wraps
        cfg_write(4'd8, {9'd4, 15'h7FFE});
        issue(1'b1, mk(38'h0, 1'b0, 3'd0, 5'h0, 2'd1, 4'h0, 15'h0555));
        check_acc("R4 beat0", 2'd1, 15'h7FFE, 1'b0, 1'b1);
        // R7: a command while busy must be refused
        cmd_vld = 1'b1; cmd_burst = 1'b0;
        cmd_word = mk(38'h0, 1'b0, 3'd0, 5'h0, 2'd2, 4'h0, 15'h0111);
        @(negedge clk);
        cmd_vld = 1'b0; cmd_word = '0;
        check_acc("R7 beat1 refused cmd", 2'd1, 15'h7FFF, 1'b0, 1'b1);
        @(negedge clk);
        check_acc("R4 beat2 wrap", 2'd1, 15'h0000, 1'b0, 1'b1);
        @(negedge clk);
        check_acc("R4 beat3 last", 2'd1, 15'h0001, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 end of burst vld", 32'(acc_vld), 0);

        // R4: length 1 on data array
        cfg_write(4'd8, {9'd1, 15'h0010});
        issue(1'b1, mk(38'h0, 1'b1, 3'd6, 5'h0, 2'd0, 4'h0, 15'h0003));
        check_acc("R4 len1", 2'd0, 15'h0010, 1'b0, 1'b0);
        @(negedge clk);
        check("R4 len1 single beat", 32'(acc_vld), 0);

        // R5: length 0 issues nothing
        cfg_write(4'd8, {9'd0, 15'h0020});
        issue(1'b1, mk(38'h0, 1'b0, 3'd0, 5'h0, 2'd0, 4'h0, 15'h0003));
        check("R5 no access", 32'(acc_vld), 0);
        check("R5 not busy", 32'(busy), 0);
        check("R5 no err", 32'(burst_err), 0);

        // R10: reset clears the result registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        issue(1'b0, mk(38'h0, 1'b1, 3'd6, 5'h0, 2'd1, 4'h0, 15'h0000));
        check_acc("R10 ssr cleared", 2'd1, 15'h0000, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule